// File: doc/BRIEF.md
# Memory protection region checker

This block judges every memory access made by a processor against a set of eight programmable protection regions. Each region is placed by a base address and a power-of-two size code. It carries its own enable, separate permission codes for instruction fetches and for data accesses, and a three-bit cache/buffer attribute. Regions may overlap. Where they do, the region with the higher number decides. A catch-all region can therefore keep user code away from dormant task memory. A single higher region is then moved by the operating system onto whichever task is running.

Each request carries an address, a privileged/user flag, a write flag and an instruction/data flag. One cycle later the block returns either an abort or the attributes the access may use: instruction caching, data caching and bufferability. A configuration port writes one region per cycle. A second port updates a global control word through a masked write. That word switches the whole unit on and gates the two cache enables.

Top module: `mpu_guard`

## Requirements
- R1: A region with size code n covers 2^(n+1) bytes. An address matches when all its bits at position n+1 and above equal the same bits of the region base, so code 11 gives 4 KB, code 14 gives 32 KB and code 31 matches every address. Codes below 11 behave as code 11.
- R2: When several enabled regions match an address, the one with the highest region index supplies the permission and the attributes.
- R3: Permission codes grant the following rights. 0 grants nothing. 1 grants privileged read/write and no user access. 2 grants privileged read/write and user read. 3 grants read/write in both modes. 5 grants privileged read and no user access. 6 grants read in both modes. 4 and 7 grant nothing. Instruction fetches are checked as reads against the instruction code. Data accesses are checked against the data code, using the write flag.
- R4: With the unit enabled, an access that matches no enabled region aborts.
- R5: An aborted access reports all three attributes as 0. Otherwise the outputs are as follows. Instruction-cache is attribute bit 2 AND control bit 12. Data-cache is attribute bit 1 AND control bit 2. Bufferable is attribute bit 0.
- R6: The response to a request appears on the cycle after it is presented, with rsp_valid high. After reset, rsp_valid is 0, the control word is 0 and every region is disabled.
- R7: A control write sets the control word to (old AND NOT mask) OR value, so bits outside the mask keep their state.
- R8: While control bit 0 is clear, every access completes without abort and all three attributes are 0.
- R9: A region whose enable bit is clear never matches. A region may be written disabled and enabled by a later write, and a rewrite (such as a move to a new base) applies to requests after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | $clog2(NREG) | Region index to write |
| cfg_base | input | AW | Region base address |
| cfg_size | input | 5 | Region size code |
| cfg_iperm | input | 3 | Instruction permission code |
| cfg_dperm | input | 3 | Data permission code |
| cfg_attr | input | 3 | Attribute: bit 2 icache, bit 1 dcache, bit 0 bufferable |
| cfg_en | input | 1 | Region enable |
| ctl_we | input | 1 | Control word write strobe |
| ctl_value | input | CTLW | Bits to set in the control word |
| ctl_mask | input | CTLW | Bits to clear before setting |
| ctl_q | output | CTLW | Current control word |
| req_valid | input | 1 | Access request present |
| req_addr | input | AW | Access address |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| req_write | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data |
| rsp_valid | output | 1 | Response present |
| rsp_abort | output | 1 | Access denied |
| rsp_icache | output | 1 | Instruction caching allowed |
| rsp_dcache | output | 1 | Data caching allowed |
| rsp_buf | output | 1 | Writes may be buffered |

## Verification
The bench keeps its own copy of the region settings and the control word. It predicts each response by dividing addresses by the region span, so it does not use masks. It probes the exact last byte and first byte past a 4 KB region, and a region given a size code below the minimum. A comparator off by one bit would misplace these edges. It places overlapping regions to catch a lowest-index-wins encoder, which would let a user task into dormant memory. It also moves a region to a new base, sweeps the reserved permission codes 4 and 7, sends instruction fetches with the write flag set, clears control bits one at a time, and uses the write-disabled-then-enable sequence. A faulty design would leak attributes on aborts, grant rights on unused codes or lose bits outside the control mask.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  // Settings of one region (base address held separately, its width is a parameter)
  typedef struct packed {
    logic       en;
    logic [4:0] size;
    logic [2:0] iperm;
    logic [2:0] dperm;
    logic [2:0] attr;
  } rgn_cfg_t;

  localparam int MIN_SIZE_CODE = 11;

  // Number of low address bits a region ignores: size code + 1, clamped at the minimum
  function automatic logic [5:0] span_bits(input logic [4:0] code);
    if (code < 5'(MIN_SIZE_CODE)) return 6'(MIN_SIZE_CODE + 1);
    return {1'b0, code} + 6'd1;
  endfunction

  // Permission decode: does a code grant this access in this mode
  function automatic logic perm_allows(input logic [2:0] code, input logic priv,
                                       input logic wr);
    case (code)
      3'd1:    return priv;
      3'd2:    return priv | ~wr;
      3'd3:    return 1'b1;
      3'd5:    return priv & ~wr;
      3'd6:    return ~wr;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mpu_region_file.sv
module mpu_region_file
  import mpu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [AW-1:0]           wr_base,
  input  rgn_cfg_t                wr_cfg,
  input  logic [AW-1:0]           addr,
  output logic [NREG-1:0]         hit_vec,
  output rgn_cfg_t [NREG-1:0]     cfg_o
);
  localparam int IW = $clog2(NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic [AW-1:0] base_q;
    rgn_cfg_t      cfg_q;
    logic [AW:0]   wide;
    logic [AW-1:0] keep_mask;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        cfg_q  <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        base_q <= wr_base;
        cfg_q  <= wr_cfg;
      end
    end

    always_comb begin
      wide      = {(AW+1){1'b1}} << span_bits(cfg_q.size);
      keep_mask = wide[AW-1:0];
    end

    assign hit_vec[g] = cfg_q.en && (((addr ^ base_q) & keep_mask) == '0);
    assign cfg_o[g]   = cfg_q;

    // R9: a disabled region never reports a hit
    a_r9_off_no_hit: assert property (@(posedge clk) disable iff (rst)
      !cfg_q.en |-> !hit_vec[g]);
  end

endmodule

// File: rtl/mpu_resolver.sv
module mpu_resolver
  import mpu_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREG-1:0]         hit_vec,
  input  rgn_cfg_t [NREG-1:0]     cfg_i,
  output logic                    any_hit,
  output logic [$clog2(NREG)-1:0] win_idx,
  output rgn_cfg_t                win_cfg
);
  localparam int IW = $clog2(NREG);

  // Later (higher-numbered) hits overwrite earlier ones
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  assign win_cfg = cfg_i[win_idx];

  // R2: the winner is itself a hit, and no higher region hits
  a_r2_winner_hits: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> hit_vec[win_idx]);
  a_r2_none_above: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> ((hit_vec >> win_idx) == NREG'(1)));
  a_r4_hit_flag: assert property (@(posedge clk) disable iff (rst)
    (hit_vec == '0) |-> !any_hit);

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int CTLW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [$clog2(NREG)-1:0] cfg_idx,
  input  logic [AW-1:0]           cfg_base,
  input  logic [4:0]              cfg_size,
  input  logic [2:0]              cfg_iperm,
  input  logic [2:0]              cfg_dperm,
  input  logic [2:0]              cfg_attr,
  input  logic                    cfg_en,
  input  logic                    ctl_we,
  input  logic [CTLW-1:0]         ctl_value,
  input  logic [CTLW-1:0]         ctl_mask,
  output logic [CTLW-1:0]         ctl_q,
  input  logic                    req_valid,
  input  logic [AW-1:0]           req_addr,
  input  logic                    req_priv,
  input  logic                    req_write,
  input  logic                    req_instr,
  output logic                    rsp_valid,
  output logic                    rsp_abort,
  output logic                    rsp_icache,
  output logic                    rsp_dcache,
  output logic                    rsp_buf
);
  localparam int IW      = $clog2(NREG);
  localparam int ON_BIT  = 0;
  localparam int DC_BIT  = 2;
  localparam int IC_BIT  = 12;

  // Named internal events
  logic                prot_on;
  logic [NREG-1:0]     hit_vec;
  rgn_cfg_t [NREG-1:0] cfg_all;
  logic                any_hit;
  logic [IW-1:0]       win_idx;
  rgn_cfg_t            win_cfg;
  logic [2:0]          use_perm;
  logic                eff_write;
  logic                allow;
  logic                abort_d;
  logic                icache_d, dcache_d, buf_d;
  rgn_cfg_t            wr_cfg;

  assign wr_cfg = '{en: cfg_en, size: cfg_size, iperm: cfg_iperm,
                    dperm: cfg_dperm, attr: cfg_attr};

  mpu_region_file #(.NREG(NREG), .AW(AW)) u_file (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base),
    .wr_cfg(wr_cfg), .addr(req_addr), .hit_vec(hit_vec), .cfg_o(cfg_all)
  );

  mpu_resolver #(.NREG(NREG)) u_res (
    .clk(clk), .rst(rst), .hit_vec(hit_vec), .cfg_i(cfg_all),
    .any_hit(any_hit), .win_idx(win_idx), .win_cfg(win_cfg)
  );

  // Control word: masked update
  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_we) ctl_q <= (ctl_q & ~ctl_mask) | ctl_value;
  end

  assign prot_on = ctl_q[ON_BIT];

  always_comb begin
    use_perm  = req_instr ? win_cfg.iperm : win_cfg.dperm;
    eff_write = req_write & ~req_instr;
    allow     = ~prot_on | (any_hit & perm_allows(use_perm, req_priv, eff_write));
    abort_d   = ~allow;
    icache_d  = prot_on & allow & win_cfg.attr[2] & ctl_q[IC_BIT];
    dcache_d  = prot_on & allow & win_cfg.attr[1] & ctl_q[DC_BIT];
    buf_d     = prot_on & allow & win_cfg.attr[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_abort  <= 1'b0;
      rsp_icache <= 1'b0;
      rsp_dcache <= 1'b0;
      rsp_buf    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_abort  <= req_valid & abort_d;
      rsp_icache <= req_valid & icache_d;
      rsp_dcache <= req_valid & dcache_d;
      rsp_buf    <= req_valid & buf_d;
    end
  end

  // R6: every request is answered on the next cycle
  a_r6_next_cycle: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R4: enabled unit with no matching region aborts
  a_r4_miss_abort: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot_on && !any_hit) |=> rsp_abort);
  // R5: aborts carry no attributes
  a_r5_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_abort |-> (!rsp_icache && !rsp_dcache && !rsp_buf));
  // R8: unit off lets everything through with attributes off
  a_r8_off_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_on) |=> (rsp_valid && !rsp_abort && !rsp_icache
                                 && !rsp_dcache && !rsp_buf));
  // R7: bits outside the mask survive a control write
  a_r7_masked_keep: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> ((ctl_q & ~$past(ctl_mask)) == ($past(ctl_q) & ~$past(ctl_mask))));

endmodule

// File: tb/mpu_guard_test.sv
module mpu_guard_test;
  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int CTLW = 32;
  localparam time HALF = 10ns;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_we = 0;
  logic [2:0]      cfg_idx = 0;
  logic [AW-1:0]   cfg_base = 0;
  logic [4:0]      cfg_size = 0;
  logic [2:0]      cfg_iperm = 0, cfg_dperm = 0, cfg_attr = 0;
  logic            cfg_en = 0;
  logic            ctl_we = 0;
  logic [CTLW-1:0] ctl_value = 0, ctl_mask = 0;
  logic [CTLW-1:0] ctl_q;
  logic            req_valid = 0;
  logic [AW-1:0]   req_addr = 0;
  logic            req_priv = 0, req_write = 0, req_instr = 0;
  logic            rsp_valid, rsp_abort, rsp_icache, rsp_dcache, rsp_buf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench-side model of the programmed state
  logic [31:0] m_base [NREG];
  int          m_size [NREG];
  int          m_ip [NREG], m_dp [NREG], m_attr [NREG];
  bit          m_en [NREG];
  logic [31:0] m_ctl;

  // Scoreboard: {abort, icache, dcache, buf}
  logic [3:0] q_exp [$];
  string      q_tag [$];

  always #HALF clk = ~clk;

  mpu_guard #(.NREG(NREG), .AW(AW), .CTLW(CTLW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_iperm(cfg_iperm), .cfg_dperm(cfg_dperm),
    .cfg_attr(cfg_attr), .cfg_en(cfg_en), .ctl_we(ctl_we), .ctl_value(ctl_value),
    .ctl_mask(ctl_mask), .ctl_q(ctl_q), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .req_write(req_write), .req_instr(req_instr),
    .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .rsp_icache(rsp_icache),
    .rsp_dcache(rsp_dcache), .rsp_buf(rsp_buf)
  );

  // Rights: 0 none, 1 read, 2 read/write
  function automatic int priv_rights(int code);
    if (code == 1 || code == 2 || code == 3) return 2;
    if (code == 5 || code == 6) return 1;
    return 0;
  endfunction

  function automatic int user_rights(int code);
    if (code == 3) return 2;
    if (code == 2 || code == 6) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] predict(logic [31:0] a, bit priv, bit wr, bit instr);
    int win = -1;
    int code, r, s;
    longint unsigned span;
    bit w, ok;
    if (!m_ctl[0]) return 4'b0000;
    for (int i = 0; i < NREG; i++) begin
      if (m_en[i]) begin
        s = (m_size[i] < 11) ? 11 : m_size[i];
        span = 64'd1 << (s + 1);
        if ((longint'(a) / span) == (longint'(m_base[i]) / span)) win = i;
      end
    end
    if (win < 0) return 4'b1000;
    code = instr ? m_ip[win] : m_dp[win];
    w  = wr && !instr;
    r  = priv ? priv_rights(code) : user_rights(code);
    ok = w ? (r == 2) : (r >= 1);
    if (!ok) return 4'b1000;
    return {1'b0, m_attr[win] >= 4 && m_ctl[12], ((m_attr[win] >> 1) & 1) == 1 && m_ctl[2],
            (m_attr[win] & 1) == 1};
  endfunction

  task automatic set_region(int i, logic [31:0] b, int sz, int ip, int dp, int at, bit en);
    cfg_idx = 3'(i); cfg_base = b; cfg_size = 5'(sz); cfg_iperm = 3'(ip);
    cfg_dperm = 3'(dp); cfg_attr = 3'(at); cfg_en = en; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    m_base[i] = b; m_size[i] = sz; m_ip[i] = ip; m_dp[i] = dp; m_attr[i] = at; m_en[i] = en;
  endtask

  task automatic ctl_write(logic [31:0] v, logic [31:0] m);
    ctl_value = v; ctl_mask = m; ctl_we = 1;
    @(negedge clk);
    ctl_we = 0;
    m_ctl = (m_ctl & ~m) | v;
  endtask

  task automatic check_ctl(logic [31:0] exp, string tag);
    checks++;
    if (ctl_q !== exp) begin
      errors++;
      $display("FAIL %s control word actual %h expected %h", tag, ctl_q, exp);
    end
  endtask

  task automatic access(logic [31:0] a, bit priv, bit wr, bit instr, string tag);
    q_exp.push_back(predict(a, priv, wr, instr));
    q_tag.push_back(tag);
    req_addr = a; req_priv = priv; req_write = wr; req_instr = instr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  // Monitor: pops one expectation per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      logic [3:0] got, exp;
      string tag;
      got = {rsp_abort, rsp_icache, rsp_dcache, rsp_buf};
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected response actual %b expected none", got);
      end else begin
        exp = q_exp.pop_front();
        tag = q_tag.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s {abort,ic,dc,buf} actual %b expected %b", tag, got, exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_ip[i] = 0; m_dp[i] = 0; m_attr[i] = 0; m_en[i] = 0;
    end
    m_ctl = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R6: reset state
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R6 rsp_valid after reset actual %b expected 0", rsp_valid);
    end
    check_ctl(32'h0, "R6");

    // R8: unit off, anything goes
    access(32'h0000_0000, 0, 1, 0, "R8 unit off");

    // Regions: catch-all, shared, devices, task (written disabled first)
    set_region(1, 32'h0000_0000, 31, 5, 1, 6, 1);
    set_region(2, 32'h0001_0000, 15, 6, 3, 6, 1);
    set_region(4, 32'h1000_0000, 20, 5, 1, 0, 1);
    set_region(3, 32'h0002_0000, 14, 6, 3, 6, 0);

    // R7: masked control writes
    ctl_write(32'h0000_1005, 32'h0000_1005);
    check_ctl(32'h0000_1005, "R7 enable bits");
    ctl_write(32'h8000_0000, 32'h8000_0000);
    check_ctl(32'h8000_1005, "R7 keep outside mask");
    ctl_write(32'h0000_0000, 32'h8000_0000);
    check_ctl(32'h0000_1005, "R7 clear one bit");

    access(32'h0002_0010, 0, 0, 0, "R9 disabled task region");
    set_region(3, 32'h0002_0000, 14, 6, 3, 6, 1);
    access(32'h0002_0010, 0, 0, 0, "R9 enabled task read");
    access(32'h0002_0010, 0, 1, 0, "R3 user write rw");
    access(32'h0002_8000, 0, 1, 0, "R2 dormant task shielded");
    access(32'h0002_8000, 1, 0, 0, "R2 privileged dormant read");
    access(32'h0001_0004, 0, 1, 0, "R2 shared over catch-all");
    access(32'h0001_0004, 0, 0, 1, "R3 user fetch ro");
    access(32'h0001_0004, 0, 1, 1, "R3 fetch ignores write flag");
    access(32'h0000_0100, 1, 0, 1, "R3 privileged fetch code 5");
    access(32'h0000_0100, 1, 1, 0, "R3 privileged data write code 1");
    access(32'h0000_0100, 0, 0, 0, "R3 user read code 1");
    access(32'h1000_0000, 0, 0, 0, "R3 user device read");
    access(32'h1000_0000, 1, 1, 0, "R5 device uncached");
    access(32'h1020_0000, 1, 1, 0, "R1 past 2MB edge");

    // Context switch: move the task region
    set_region(3, 32'h0002_8000, 14, 6, 3, 6, 1);
    access(32'h0002_0000, 0, 0, 0, "R9 old task now shielded");
    access(32'h0002_8004, 0, 0, 0, "R9 moved task reachable");

    // 4 KB region with code 2 and attribute 3
    set_region(5, 32'h0004_0000, 11, 6, 2, 3, 1);
    access(32'h0004_0000, 0, 0, 0, "R3 code 2 user read");
    access(32'h0004_0000, 0, 1, 0, "R3 code 2 user write");
    access(32'h0004_0FFF, 1, 0, 0, "R1 last byte of 4KB");
    access(32'h0004_1000, 1, 0, 0, "R1 first byte past 4KB");
    set_region(5, 32'h0004_0000, 11, 6, 4, 3, 1);
    access(32'h0004_0000, 1, 0, 0, "R3 code 4 none");
    set_region(5, 32'h0004_0000, 11, 6, 7, 3, 1);
    access(32'h0004_0000, 1, 0, 0, "R3 code 7 none");
    set_region(5, 32'h0004_0000, 11, 6, 0, 3, 1);
    access(32'h0004_0000, 1, 0, 0, "R3 code 0 none");

    // Undersized code clamps to 4 KB
    set_region(6, 32'h0005_0000, 5, 6, 3, 1, 1);
    access(32'h0005_0FFF, 0, 0, 0, "R1 small code clamp inside");
    access(32'h0005_1000, 0, 0, 0, "R1 small code clamp outside");

    // Cache gates in the control word
    ctl_write(32'h0000_0000, 32'h0000_0004);
    check_ctl(32'h0000_1001, "R7 dcache off");
    access(32'h0002_8004, 1, 0, 0, "R5 dcache gated");
    ctl_write(32'h0000_0000, 32'h0000_1000);
    access(32'h0002_8004, 1, 0, 0, "R5 icache gated");

    // No region: abort
    set_region(1, 32'h0000_0000, 31, 5, 1, 6, 0);
    access(32'h2000_0000, 1, 0, 0, "R4 no match privileged");
    access(32'h2000_0000, 0, 1, 0, "R4 no match user");

    // Unit off again
    ctl_write(32'h0000_0000, 32'h0000_0001);
    access(32'h2000_0000, 0, 1, 0, "R8 unit off again");

    repeat (3) @(negedge clk);
    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R6 responses missing actual %0d expected 0", q_exp.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule